// File: doc/BRIEF.md
# Boundary-Scan Register with Pin-Type Cells

This block is the boundary data register that sits between the core and the pads of a chip. Each functional pin is given a group of scan cells that matches its type. An input-only pin gets one sensing cell. An output-only pin gets a data cell and an enable cell. A bidirectional pin gets all three. The list of pin types is a parameter, and the chain length is the sum of the cells in all the groups.

A TAP controller drives the block with three level strobes and two instruction decodes. The strobes are `capture_dr`, `shift_dr` and `update_dr`, each high for the whole TCK cycle of its controller state. The decodes are `sel_extest` and `sel_sample`. Serial data comes in on `tdi`, and `scan_out` goes back to the TAP's output multiplexer.

With neither instruction selected, the core drives the pads directly. In EXTEST, the pads are driven from update latches that load on the falling edge of TCK. Those latches can be preloaded under SAMPLE.

A small phase tracker follows the data-register sequence. Its states are:
- `PH_IDLE`: no scan in progress.
- `PH_CAPTURED`: a capture has just happened.
- `PH_SHIFTING`: shifting is under way.
- `PH_PAUSED`: the sequence is in an exit or pause state.

Its transitions are:
- Any state goes to `PH_IDLE` on loss of selection or on an update strobe.
- Any state goes to `PH_CAPTURED` on a capture strobe.
- Any state other than `PH_IDLE` goes to `PH_SHIFTING` on a shift strobe.
- `PH_CAPTURED` and `PH_SHIFTING` go to `PH_PAUSED` when no strobe is present.

An update strobe reaches the latches only when the tracker is not idle.

Top module: `bscan_register`

## Requirements
- R1: Pin p uses the two bits `PIN_KIND[2p+1:2p]`. Code 0 means input-only (1 cell), code 1 means output-only (2 cells), and codes 2 and 3 mean bidirectional (3 cells). Pin 0's cells sit nearest `scan_out`, then pin 1's, and so on. Within a pin, the order from the `scan_out` side is input cell, data cell, enable cell, leaving out any cell the type lacks. The chain length is the sum of the cell counts.
- R2: On a selected capture strobe, every input cell loads `pad_di` of its pin. Every data cell loads the value `pad_do` presents, and every enable cell loads the value `pad_oe` presents. In SAMPLE these are the core values; in EXTEST they are the update-latch values.
- R3: On each selected shift cycle, the chain moves one place toward `scan_out`, and `tdi` enters the cell farthest from it. `scan_out` always shows cell 0. After chain-length shifts, the chain holds the shifted-in bits, with the first one at cell 0.
- R4: On the falling TCK edge during a selected update strobe, the data and enable update latches load their chain cells. They load only if a capture has occurred since selection began or since the last update. Otherwise the strobe is ignored.
- R5: While `sel_extest` is high, `pad_do` and `pad_oe` of every output-capable pin follow the update latches. They do not follow the core, and they hold steady through capture and shift.
- R6: While `sel_extest` is low, `pad_do` and `pad_oe` equal `core_do` and `core_oe` for output-capable pins, even after an update under SAMPLE.
- R7: With both `sel_extest` and `sel_sample` low, the capture, shift and update strobes leave the chain and the latches unchanged.
- R8: While `rst_n` is low, all chain cells and update latches clear. After reset, `scan_out` is 0, and EXTEST without a prior update drives all pads with data 0 and enable 0.
- R9: `core_di` equals `pad_di` for input-capable pins and is 0 for output-only pins. `pad_do` and `pad_oe` are 0 for input-only pins.
- R10: The phase tracker leaves `PH_IDLE` only on a selected capture strobe, and it returns to `PH_IDLE` whenever selection drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the chain uses the rising edge, the update latches the falling edge |
| rst_n | input | 1 | Active-low asynchronous test reset |
| sel_extest | input | 1 | EXTEST instruction decode |
| sel_sample | input | 1 | SAMPLE instruction decode |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out, to the TDO multiplexer |
| core_do | input | NPINS | Output data from the core, per pin |
| core_oe | input | NPINS | Output enable from the core, per pin |
| core_di | output | NPINS | Input data to the core, per pin |
| pad_di | input | NPINS | Level received from each pad |
| pad_do | output | NPINS | Output data to each pad |
| pad_oe | output | NPINS | Output enable to each pad |

## Verification
The bench preloads the update latches under SAMPLE and then enters EXTEST without a scan. A design that blocked the update under SAMPLE, or let it reach the pads, would show the wrong pad levels here. During an EXTEST shift it changes the core outputs and looks at the pads mid-shift, which catches latches that are transparent or pads that still follow the core. It also issues an update strobe after a shift that had no capture, and a full capture, shift and update sequence with no instruction selected. A design with a missing arming guard, or with ungated strobes, would corrupt the pads or the bit at `scan_out`. Every shifted-out bit is compared against a capture vector built from the cell layout, so a swapped cell order or a wrong shift direction shows up at once.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        PIN_IN    = 2'd0,
        PIN_OUT   = 2'd1,
        PIN_BIDIR = 2'd2
    } pin_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_CAPTURED = 2'd1,
        PH_SHIFTING = 2'd2,
        PH_PAUSED   = 2'd3
    } scan_phase_e;

    // Number of scan cells a pin of the given kind contributes.
    function automatic int kind_cells(logic [1:0] kind);
        if (kind == PIN_IN)
            return 1;
        else if (kind == PIN_OUT)
            return 2;
        else
            return 3;
    endfunction

endpackage

// File: rtl/bscan_phase_fsm.sv
module bscan_phase_fsm
    import bscan_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic sel,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    output logic cap_en,
    output logic shf_en,
    output logic upd_en
);

    scan_phase_e phase_q, phase_d;

    // State register
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (sel && capture_dr)
                    phase_d = PH_CAPTURED;
            end
            PH_CAPTURED, PH_SHIFTING: begin
                if (!sel || update_dr)
                    phase_d = PH_IDLE;
                else if (capture_dr)
                    phase_d = PH_CAPTURED;
                else if (shift_dr)
                    phase_d = PH_SHIFTING;
                else
                    phase_d = PH_PAUSED;
            end
            PH_PAUSED: begin
                if (!sel || update_dr)
                    phase_d = PH_IDLE;
                else if (capture_dr)
                    phase_d = PH_CAPTURED;
                else if (shift_dr)
                    phase_d = PH_SHIFTING;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Output logic: strobes gated by selection; update armed only mid-sequence
    always_comb begin
        cap_en = sel && capture_dr;
        shf_en = sel && shift_dr && !capture_dr;
        upd_en = sel && update_dr && (phase_q != PH_IDLE);
    end

    // R10: a non-idle phase implies selection was present on the previous edge
    assert_phase_needs_sel_R10: assert property (@(posedge tck) disable iff (!rst_n)
        (phase_q != PH_IDLE) |-> $past(sel));

    // R10: losing selection always brings the tracker back to idle
    assert_drop_to_idle_R10: assert property (@(posedge tck) disable iff (!rst_n)
        !sel |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/bscan_shift_chain.sv
module bscan_shift_chain #(
    parameter int LEN = 9
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic           shf_en,
    input  logic [LEN-1:0] cap_vec,
    input  logic           tdi,
    output logic [LEN-1:0] chain_q,
    output logic           scan_out
);

    generate
        if (LEN == 1) begin : g_single
            always_ff @(posedge tck or negedge rst_n) begin
                if (!rst_n)
                    chain_q <= '0;
                else if (cap_en)
                    chain_q <= cap_vec;
                else if (shf_en)
                    chain_q <= tdi;
            end
        end else begin : g_multi
            always_ff @(posedge tck or negedge rst_n) begin
                if (!rst_n)
                    chain_q <= '0;
                else if (cap_en)
                    chain_q <= cap_vec;
                else if (shf_en)
                    chain_q <= {tdi, chain_q[LEN-1:1]};
            end

            // R3: a shift moves every cell one place toward scan_out
            assert_shift_step_R3: assert property (@(posedge tck) disable iff (!rst_n)
                (shf_en && !cap_en) |=> (chain_q[LEN-2:0] == $past(chain_q[LEN-1:1])));
        end
    endgenerate

    assign scan_out = chain_q[0];

    // R3: the farthest cell takes tdi on a shift
    assert_tdi_entry_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (shf_en && !cap_en) |=> (chain_q[LEN-1] == $past(tdi)));

    // R7: without an enabled strobe the chain holds
    assert_chain_hold_R7: assert property (@(posedge tck) disable iff (!rst_n)
        (!cap_en && !shf_en) |=> $stable(chain_q));

endmodule

// File: rtl/bscan_pin_cells.sv
module bscan_pin_cells
    import bscan_pkg::*;
#(
    parameter logic [1:0] KIND  = 2'd2,
    parameter int          NCELL = 3
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             extest,
    input  logic             upd_en,
    input  logic             core_do,
    input  logic             core_oe,
    input  logic             pad_di,
    input  logic [NCELL-1:0] upd_bits,
    output logic [NCELL-1:0] cap_bits,
    output logic             pad_do,
    output logic             pad_oe,
    output logic             core_di
);

    localparam bit HAS_IN  = (KIND != PIN_OUT);
    localparam bit HAS_OUT = (KIND != PIN_IN);
    localparam int DO_IDX  = HAS_IN ? 1 : 0;
    localparam int OE_IDX  = DO_IDX + 1;

    generate
        if (HAS_OUT) begin : g_drive
            logic do_q, oe_q;

            // Update latches: falling edge, only when the sequencer arms them
            always_ff @(negedge tck or negedge rst_n) begin
                if (!rst_n) begin
                    do_q <= 1'b0;
                    oe_q <= 1'b0;
                end else if (upd_en) begin
                    do_q <= upd_bits[DO_IDX];
                    oe_q <= upd_bits[OE_IDX];
                end
            end

            assign pad_do = extest ? do_q : core_do;
            assign pad_oe = extest ? oe_q : core_oe;
            assign cap_bits[DO_IDX] = pad_do;
            assign cap_bits[OE_IDX] = pad_oe;

            // R4: latches change only at an armed update edge
            assert_latch_hold_R4: assert property (@(negedge tck) disable iff (!rst_n)
                !upd_en |=> $stable({do_q, oe_q}));

            // R5: in EXTEST the pads hold while the latches hold
            assert_extest_hold_R5: assert property (@(posedge tck) disable iff (!rst_n)
                (extest && $past(extest) && $stable({do_q, oe_q})) |-> $stable({pad_do, pad_oe}));
        end else begin : g_nodrive
            assign pad_do = 1'b0;
            assign pad_oe = 1'b0;
            logic unused_drive;
            assign unused_drive = ^{core_do, core_oe, upd_bits, extest, upd_en, tck, rst_n};
        end

        if (HAS_IN) begin : g_sense
            assign core_di     = pad_di;
            assign cap_bits[0] = pad_di;
            logic unused_in_upd;
            assign unused_in_upd = upd_bits[0];
        end else begin : g_nosense
            assign core_di = 1'b0;
            logic unused_sense;
            assign unused_sense = pad_di;
        end
    endgenerate

endmodule

// File: rtl/bscan_register.sv
module bscan_register
    import bscan_pkg::*;
#(
    parameter int                 NPINS    = 4,
    parameter logic [2*NPINS-1:0] PIN_KIND = 8'b10_01_00_10
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             sel_extest,
    input  logic             sel_sample,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    output logic             scan_out,
    input  logic [NPINS-1:0] core_do,
    input  logic [NPINS-1:0] core_oe,
    output logic [NPINS-1:0] core_di,
    input  logic [NPINS-1:0] pad_di,
    output logic [NPINS-1:0] pad_do,
    output logic [NPINS-1:0] pad_oe
);

    // First chain position of pin p (sum of the cells of all lower pins)
    function automatic int cell_base(int p);
        int acc;
        acc = 0;
        for (int i = 0; i < p; i++)
            acc += kind_cells(PIN_KIND[2*i +: 2]);
        return acc;
    endfunction

    localparam int CHAIN_LEN = cell_base(NPINS);

    logic                 sel;
    logic                 cap_en, shf_en, upd_en;
    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] chain_q;

    assign sel = sel_extest || sel_sample;

    bscan_phase_fsm u_phase (
        .tck        (tck),
        .rst_n      (rst_n),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .cap_en     (cap_en),
        .shf_en     (shf_en),
        .upd_en     (upd_en)
    );

    bscan_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
        .tck      (tck),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .shf_en   (shf_en),
        .cap_vec  (cap_vec),
        .tdi      (tdi),
        .chain_q  (chain_q),
        .scan_out (scan_out)
    );

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_pin
            localparam logic [1:0] K    = PIN_KIND[2*g +: 2];
            localparam int         NC   = kind_cells(K);
            localparam int         BASE = cell_base(g);

            bscan_pin_cells #(.KIND(K), .NCELL(NC)) u_cells (
                .tck      (tck),
                .rst_n    (rst_n),
                .extest   (sel_extest),
                .upd_en   (upd_en),
                .core_do  (core_do[g]),
                .core_oe  (core_oe[g]),
                .pad_di   (pad_di[g]),
                .upd_bits (chain_q[BASE +: NC]),
                .cap_bits (cap_vec[BASE +: NC]),
                .pad_do   (pad_do[g]),
                .pad_oe   (pad_oe[g]),
                .core_di  (core_di[g])
            );
        end
    endgenerate

    // R2: a selected capture loads the pin-side vector assembled by the cells
    assert_capture_R2: assert property (@(posedge tck) disable iff (!rst_n)
        cap_en |=> (chain_q == $past(cap_vec)));

    // R7: with no instruction selected, no strobe reaches chain or latches
    assert_unselected_R7: assert property (@(posedge tck) disable iff (!rst_n)
        !sel |-> (!cap_en && !shf_en && !upd_en));

endmodule

// File: tb/bscan_register_bench.sv
`timescale 1ns/1ps
module bscan_register_bench;

    localparam int LEN = 9;
    localparam logic [3:0] OUT_MASK = 4'b1101;
    localparam logic [3:0] IN_MASK  = 4'b1011;
    localparam int DO_CELL [4] = '{1, 0, 4, 7};
    localparam int OE_CELL [4] = '{2, 0, 5, 8};
    localparam int IN_CELL [4] = '{0, 3, 0, 6};

    logic tck = 1'b0, rst_n = 1'b0;
    logic sel_extest = 1'b0, sel_sample = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic [3:0] core_do = '0, core_oe = '0, pad_di = '0;
    logic scan_out;
    logic [3:0] core_di, pad_do, pad_oe;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic exp_q[$];
    logic [LEN-1:0] lat_m = '0;

    always #2.5 tck = ~tck;

    bscan_register #(.NPINS(4), .PIN_KIND(8'b10_01_00_10)) u_bscan_register (
        .tck(tck), .rst_n(rst_n), .sel_extest(sel_extest), .sel_sample(sel_sample),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .scan_out(scan_out), .core_do(core_do), .core_oe(core_oe),
        .core_di(core_di), .pad_di(pad_di), .pad_do(pad_do), .pad_oe(pad_oe)
    );

    function automatic logic [3:0] exp_pdo(bit ext);
        logic [3:0] r;
        for (int p = 0; p < 4; p++)
            r[p] = OUT_MASK[p] ? (ext ? lat_m[DO_CELL[p]] : core_do[p]) : 1'b0;
        return r;
    endfunction

    function automatic logic [3:0] exp_poe(bit ext);
        logic [3:0] r;
        for (int p = 0; p < 4; p++)
            r[p] = OUT_MASK[p] ? (ext ? lat_m[OE_CELL[p]] : core_oe[p]) : 1'b0;
        return r;
    endfunction

    function automatic logic [LEN-1:0] exp_cap(bit ext);
        logic [LEN-1:0] c;
        logic [3:0] pdo, poe;
        c = '0;
        pdo = exp_pdo(ext);
        poe = exp_poe(ext);
        for (int p = 0; p < 4; p++) begin
            if (IN_MASK[p]) c[IN_CELL[p]] = pad_di[p];
            if (OUT_MASK[p]) begin
                c[DO_CELL[p]] = pdo[p];
                c[OE_CELL[p]] = poe[p];
            end
        end
        return c;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    task automatic sample_pt();
        @(negedge tck);
        #1;
    endtask

    task automatic check_pads(string req, bit ext);
        chk({req, " pad_do"}, 32'(pad_do), 32'(exp_pdo(ext)));
        chk({req, " pad_oe"}, 32'(pad_oe), 32'(exp_poe(ext)));
        chk("R9 core_di", 32'(core_di), 32'(pad_di & IN_MASK));
    endtask

    // Driver: capture, shift vin in (expected capture bits to scoreboard), update
    task automatic do_scan(logic [LEN-1:0] vin, bit ext, string upd_req);
        logic [LEN-1:0] cap;
        cap = exp_cap(ext);
        for (int j = 0; j < LEN; j++) exp_q.push_back(cap[j]);
        tick();
        capture_dr = 1'b1;
        for (int j = 0; j < LEN; j++) begin
            tick();
            capture_dr = 1'b0;
            shift_dr = 1'b1;
            tdi = vin[j];
            if (j == 4) begin
                sample_pt();
                check_pads("R5 mid-shift", ext);
            end
        end
        tick();
        shift_dr = 1'b0;
        tick();
        update_dr = 1'b1;
        sample_pt();
        lat_m = vin;
        check_pads(upd_req, ext);
        tick();
        update_dr = 1'b0;
    endtask

    // Monitor: compare each selected shift cycle's scan_out against the queue
    initial begin
        forever begin
            @(negedge tck);
            #1;
            if (shift_dr && (sel_extest || sel_sample)) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected shift", 32'(scan_out), 32'h2);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    chk("R1/R2/R3 scan_out bit", 32'(scan_out), 32'(e));
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        core_do = 4'b1010;
        core_oe = 4'b1111;
        pad_di  = 4'b0110;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        sample_pt();
        // R8 reset state, R6 pass-through, R9 input/output-only pins
        chk("R8 scan_out after reset", 32'(scan_out), 32'h0);
        check_pads("R6 pass-through", 1'b0);

        // R8: EXTEST straight after reset drives cleared latches
        tick();
        sel_extest = 1'b1;
        sample_pt();
        check_pads("R8 extest after reset", 1'b1);
        chk("R8 pad_oe all off", 32'(pad_oe), 32'h0);
        tick();
        sel_extest = 1'b0;

        // SAMPLE scan with preload; pads must keep following the core (R6)
        tick();
        sel_sample = 1'b1;
        do_scan(9'h1A5, 1'b0, "R6 sample update");

        // R5 / R4: switching to EXTEST exposes the preloaded latches
        tick();
        sel_sample = 1'b0;
        sel_extest = 1'b1;
        sample_pt();
        check_pads("R5 preload visible", 1'b1);

        // EXTEST scan: new pad levels, core changes must not reach pads (R5)
        tick();
        pad_di  = 4'b1001;
        core_do = 4'b0101;
        core_oe = 4'b0000;
        do_scan(9'h0DB, 1'b1, "R5 extest update");

        // R4: shift without capture, then update: must be ignored
        for (int j = 0; j < LEN; j++) exp_q.push_back(lat_m[j]);
        for (int j = 0; j < LEN; j++) begin
            tick();
            shift_dr = 1'b1;
            tdi = (9'h155 >> j) & 1;
        end
        tick();
        shift_dr = 1'b0;
        tick();
        update_dr = 1'b1;
        sample_pt();
        check_pads("R4 unarmed update", 1'b1);
        tick();
        update_dr = 1'b0;
        chk("R3 scan_out after reshift", 32'(scan_out), 32'h1);

        // R7: full sequence with nothing selected; chain keeps 9'h155
        sel_extest = 1'b0;
        pad_di = 4'b1000;
        tick();
        capture_dr = 1'b1;
        for (int j = 0; j < 3; j++) begin
            tick();
            capture_dr = 1'b0;
            shift_dr = 1'b1;
            tdi = 1'b0;
        end
        tick();
        shift_dr = 1'b0;
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
        sample_pt();
        chk("R7 scan_out untouched", 32'(scan_out), 32'h1);
        check_pads("R6 unselected", 1'b0);

        // R7: latches untouched too; EXTEST still shows the 9'h0DB contents
        tick();
        sel_extest = 1'b1;
        sample_pt();
        check_pads("R7 latches untouched", 1'b1);

        chk("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule